// File: doc/BRIEF.md
# Segmented gamma curve stage

This block applies a gamma transfer curve to a stream of 10-bit RGB pixels. It holds no full lookup table per curve. The input range is cut into 64 equal segments of 16 codes each. Each segment is described by one packed 32-bit word that gives the curve value at the start of the segment and the rise across the segment. The output is found by linear interpolation inside the segment. Three curves are built into the block when it is elaborated, with exponents 5/9, 1/2 and 5/11. A per-pixel select input picks one of them. The same curve is applied to the red, green and blue lanes in parallel.

Pixels arrive with a valid strobe and leave two clock cycles later with a matching valid strobe. A per-pixel bypass input sends the components through unchanged with the same latency. The stage therefore sits in a video pipeline without any change to the timing of its neighbours.

Top module: `gam_pwl_top`

## Requirements
- R1: While rst_ni is low and after its release, until the first valid pixel reaches the output, valid_o is 0 and r_o, g_o and b_o are 0.
- R2: A pixel accepted on a rising edge with valid_i high appears on the outputs after the next rising edge, so the latency is two cycles. valid_o at each edge equals valid_i two edges earlier.
- R3: Input bits 9:4 select the segment k and bits 3:0 form the fraction f. The output is base_k + ((slope_k * f) >> 4), clamped to 1023.
- R4: Let F(x) be the largest integer y with y^n <= 1024^(n-m) * x^m. Bank 0 uses m/n = 5/9, bank 1 uses 1/2 and bank 2 uses 5/11. Then base_k = F(16k) and slope_k = F(16k+16) - F(16k). Each packed word holds the base in bits 25:16 and the slope in bits 15:0.
- R5: Bank code 3 on bank_i selects the same curve as code 2.
- R6: With bypass_i high, each output component equals its input component, with the same two-cycle latency.
- R7: The three lanes are computed independently with the curve selected for that pixel. Equal inputs on two lanes give equal outputs.
- R8: bank_i and bypass_i are taken with each pixel. A change between consecutive pixels applies only to the pixel it arrives with, even when the earlier pixels are still in flight.
- R9: When no pixel reaches the output, valid_o is 0 and r_o, g_o and b_o keep their previous values.
- R10: An input of 0 gives 0 on every curve. An input of 1023 gives a value no higher than 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel strobe |
| r_i | input | 10 | Red component in |
| g_i | input | 10 | Green component in |
| b_i | input | 10 | Blue component in |
| bank_i | input | 2 | Curve select: 0, 1, 2 (3 acts as 2) |
| bypass_i | input | 1 | Pass this pixel through unchanged |
| valid_o | output | 1 | Output pixel strobe |
| r_o | output | 10 | Red component out |
| g_o | output | 10 | Green component out |
| b_o | output | 10 | Blue component out |

## Verification
Curve selection and bypass can change on the same pixel, while two older pixels with other settings are still in the pipeline. The bench provokes this by drawing a new bank code and a new bypass flag for every pixel of a back-to-back stream. It also mixes in bank code 3 and gaps in the valid strobe. A behavioural model recomputes every expected output from its own integer version of the curves. It delays the results by two cycles and compares them with all three lanes on every clock, so a setting that leaks into a neighbouring pixel shows up as a mismatch.

// File: rtl/gam_pkg.sv
package gam_pkg;
  localparam int GAM_PIX_W   = 10;
  localparam int GAM_FRAC_W  = 4;
  localparam int GAM_N_BANKS = 3;
  localparam int GAM_ENT_W   = 32;
  localparam int GAM_BASE_LSB = 16;

  function automatic logic [127:0] ipow(input logic [127:0] b, input int e);
    logic [127:0] r;
    r = 128'd1;
    for (int i = 0; i < e; i++) r = r * b;
    return r;
  endfunction

  // F(x): largest y with y^n <= (2^pw)^(n-m) * x^m
  function automatic int curve_pt(input int bank, input int x, input int pw);
    int m, n, y, t;
    logic [127:0] rhs;
    case (bank)
      0:       begin m = 5; n = 9;  end
      1:       begin m = 1; n = 2;  end
      default: begin m = 5; n = 11; end
    endcase
    rhs = ipow(128'(x), m) << (pw * (n - m));
    y = 0;
    for (int bt = pw; bt >= 0; bt--) begin
      t = y | (1 << bt);
      if (t <= (1 << pw)) begin
        if (ipow(128'(t), n) <= rhs) y = t;
      end
    end
    return y;
  endfunction

  function automatic logic [GAM_ENT_W-1:0] seg_entry(input int bank, input int k,
                                                     input int pw, input int fw);
    int base, nxt;
    base = curve_pt(bank, k << fw, pw);
    nxt  = curve_pt(bank, (k + 1) << fw, pw);
    return (GAM_ENT_W'(base) << GAM_BASE_LSB) | GAM_ENT_W'(nxt - base);
  endfunction
endpackage

// File: rtl/gam_rom.sv
module gam_rom
  import gam_pkg::*;
#(
  parameter int PIX_W   = GAM_PIX_W,
  parameter int FRAC_W  = GAM_FRAC_W,
  parameter int N_BANKS = GAM_N_BANKS,
  parameter int BANK_W  = $clog2(N_BANKS),
  localparam int SEG_W  = PIX_W - FRAC_W,
  localparam int N_SEG  = 1 << SEG_W
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [SEG_W-1:0]  seg_i,
  output logic [PIX_W-1:0]  base_o,
  output logic [PIX_W:0]    slope_o
);
  logic [PIX_W-1:0] base_tbl  [N_BANKS][N_SEG];
  logic [PIX_W:0]   slope_tbl [N_BANKS][N_SEG];
  logic [BANK_W-1:0] bsel;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    for (genvar k = 0; k < N_SEG; k++) begin : g_seg
      localparam logic [GAM_ENT_W-1:0] ENT = seg_entry(b, k, PIX_W, FRAC_W);
      assign base_tbl[b][k]  = ENT[GAM_BASE_LSB +: PIX_W];
      assign slope_tbl[b][k] = ENT[PIX_W:0];
    end
  end

  // out-of-range codes fall back to the last bank
  assign bsel    = (int'(bank_i) >= N_BANKS) ? BANK_W'(N_BANKS - 1) : bank_i;
  assign base_o  = base_tbl[bsel][seg_i];
  assign slope_o = slope_tbl[bsel][seg_i];
endmodule

// File: rtl/gam_interp.sv
module gam_interp #(
  parameter int PIX_W  = 10,
  parameter int FRAC_W = 4
) (
  input  logic [PIX_W-1:0]  base_i,
  input  logic [PIX_W:0]    slope_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [PIX_W-1:0]  raw_i,
  input  logic              bypass_i,
  output logic [PIX_W-1:0]  y_o
);
  localparam int PROD_W = PIX_W + 1 + FRAC_W;
  localparam int SUM_W  = PIX_W + 2;
  localparam logic [SUM_W-1:0] MAX_V = SUM_W'((1 << PIX_W) - 1);

  logic [PROD_W-1:0] prod;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    prod = PROD_W'(slope_i) * PROD_W'(frac_i);
    sum  = SUM_W'(base_i) + SUM_W'(prod >> FRAC_W);
    if (bypass_i)        y_o = raw_i;
    else if (sum > MAX_V) y_o = MAX_V[PIX_W-1:0];
    else                 y_o = sum[PIX_W-1:0];
  end
endmodule

// File: rtl/gam_lane.sv
module gam_lane
  import gam_pkg::*;
#(
  parameter int PIX_W   = GAM_PIX_W,
  parameter int FRAC_W  = GAM_FRAC_W,
  parameter int N_BANKS = GAM_N_BANKS,
  parameter int BANK_W  = $clog2(N_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load1_i,
  input  logic              load2_i,
  input  logic              bypass1_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [PIX_W-1:0]  x_i,
  output logic [PIX_W-1:0]  y_o
);
  logic [PIX_W-1:0]  base_d, base_q, raw_q, y_d, y_q;
  logic [PIX_W:0]    slope_d, slope_q;
  logic [FRAC_W-1:0] frac_q;

  gam_rom #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .N_BANKS(N_BANKS), .BANK_W(BANK_W)) u_rom (
    .bank_i (bank_i),
    .seg_i  (x_i[PIX_W-1:FRAC_W]),
    .base_o (base_d),
    .slope_o(slope_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      slope_q <= '0;
      frac_q  <= '0;
      raw_q   <= '0;
    end else if (load1_i) begin
      base_q  <= base_d;
      slope_q <= slope_d;
      frac_q  <= x_i[FRAC_W-1:0];
      raw_q   <= x_i;
    end
  end

  gam_interp #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_interp (
    .base_i  (base_q),
    .slope_i (slope_q),
    .frac_i  (frac_q),
    .raw_i   (raw_q),
    .bypass_i(bypass1_i),
    .y_o     (y_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      y_q <= '0;
    else if (load2_i) y_q <= y_d;
  end

  assign y_o = y_q;
endmodule

// File: rtl/gam_pwl_top.sv
module gam_pwl_top
  import gam_pkg::*;
#(
  parameter int PIX_W   = GAM_PIX_W,
  parameter int FRAC_W  = GAM_FRAC_W,
  parameter int N_BANKS = GAM_N_BANKS,
  localparam int BANK_W = $clog2(N_BANKS),
  localparam int N_LANE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [PIX_W-1:0]  r_i,
  input  logic [PIX_W-1:0]  g_i,
  input  logic [PIX_W-1:0]  b_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              bypass_i,
  output logic              valid_o,
  output logic [PIX_W-1:0]  r_o,
  output logic [PIX_W-1:0]  g_o,
  output logic [PIX_W-1:0]  b_o
);
  logic v1_q, v2_q, byp1_q;
  logic [PIX_W-1:0] lane_in  [N_LANE];
  logic [PIX_W-1:0] lane_out [N_LANE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      byp1_q <= 1'b0;
    end else begin
      v1_q <= valid_i;
      v2_q <= v1_q;
      if (valid_i) byp1_q <= bypass_i;
    end
  end

  assign lane_in[0] = r_i;
  assign lane_in[1] = g_i;
  assign lane_in[2] = b_i;

  for (genvar c = 0; c < N_LANE; c++) begin : g_lane
    gam_lane #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .N_BANKS(N_BANKS), .BANK_W(BANK_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load1_i  (valid_i),
      .load2_i  (v1_q),
      .bypass1_i(byp1_q),
      .bank_i   (bank_i),
      .x_i      (lane_in[c]),
      .y_o      (lane_out[c])
    );
  end

  assign valid_o = v2_q;
  assign r_o     = lane_out[0];
  assign g_o     = lane_out[1];
  assign b_o     = lane_out[2];
endmodule

// File: rtl/gam_pwl_chk.sv
module gam_pwl_chk #(
  parameter int PIX_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             bypass_i,
  input logic [PIX_W-1:0] r_i,
  input logic [PIX_W-1:0] g_i,
  input logic             valid_o,
  input logic [PIX_W-1:0] r_o,
  input logic [PIX_W-1:0] g_o,
  input logic [PIX_W-1:0] b_o
);
  logic [1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_q <= 2'd0;
    else if (since_q != 2'd3) since_q <= since_q + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 2'd2) |-> (valid_o == $past(valid_i, 2))); // R2

  AST_BYPASS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 2'd2 && valid_o && $past(bypass_i, 2)) |-> (r_o == $past(r_i, 2))); // R6

  AST_ZERO_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 2'd2 && valid_o && !$past(bypass_i, 2) && $past(r_i, 2) == '0) |-> (r_o == '0)); // R10

  AST_LANE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 2'd2 && valid_o && $past(r_i, 2) == $past(g_i, 2)) |-> (r_o == g_o)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 2'd1 && !valid_o) |-> $stable({r_o, g_o, b_o})); // R9
endmodule

bind gam_pwl_top gam_pwl_chk #(.PIX_W(PIX_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .bypass_i(bypass_i),
  .r_i     (r_i),
  .g_i     (g_i),
  .valid_o (valid_o),
  .r_o     (r_o),
  .g_o     (g_o),
  .b_o     (b_o)
);

// File: tb/gam_pwl_top_tb_top.sv
module gam_pwl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0, bypass_i = 1'b0;
  logic [9:0] r_i = '0, g_i = '0, b_i = '0;
  logic [1:0] bank_i = '0;
  logic valid_o;
  logic [9:0] r_o, g_o, b_o;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  gam_pwl_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .r_i(r_i), .g_i(g_i), .b_i(b_i), .bank_i(bank_i), .bypass_i(bypass_i),
    .valid_o(valid_o), .r_o(r_o), .g_o(g_o), .b_o(b_o)
  );

  int total = 0, bad = 0, cyc = 0;
  int ftab [3][65];

  // model: stage 1 and output stage
  logic m1_v = 1'b0, mo_v = 1'b0;
  int m1_r = 0, m1_g = 0, m1_b = 0, mo_r = 0, mo_g = 0, mo_b = 0;
  string m1_t = "R1", mo_t = "R1";

  function automatic logic [127:0] pw128(input int b, input int e);
    logic [127:0] r = 128'd1;
    for (int i = 0; i < e; i++) r = r * 128'(b);
    return r;
  endfunction

  function automatic int ref_curve(input int m, input int n, input int x);
    logic [127:0] rhs = pw128(x, m) << (10 * (n - m));
    int y = 0;
    while (y < 1024 && pw128(y + 1, n) <= rhs) y++;
    return y;
  endfunction

  function automatic int expv(input int bk, input logic byp, input int x);
    int c, s, f, base, sl, v;
    if (byp) return x;
    c = (bk > 2) ? 2 : bk;
    s = x / 16;
    f = x % 16;
    base = ftab[c][s];
    sl = ftab[c][s + 1] - base;
    v = base + (sl * f) / 16;
    return (v > 1023) ? 1023 : v;
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic check_out();
    total++;
    if (valid_o !== mo_v || r_o !== 10'(mo_r) || g_o !== 10'(mo_g) || b_o !== 10'(mo_b)) begin
      bad++;
      $display("FAIL %s: got v=%0b r=%0d g=%0d b=%0d exp v=%0b r=%0d g=%0d b=%0d",
               mo_t, valid_o, r_o, g_o, b_o, mo_v, mo_r, mo_g, mo_b);
    end
  endtask

  task automatic step(input logic v, input int r, input int g, input int b,
                      input int bk, input logic byp, input string tag);
    @(negedge clk_i);
    check_out();
    valid_i  = v;
    r_i      = 10'(r);
    g_i      = 10'(g);
    b_i      = 10'(b);
    bank_i   = 2'(bk);
    bypass_i = byp;
    mo_v = m1_v;
    if (m1_v) begin
      mo_r = m1_r; mo_g = m1_g; mo_b = m1_b; mo_t = m1_t;
    end else begin
      mo_t = (mo_t == "R1") ? "R1" : "R9";
    end
    m1_v = v;
    if (v) begin
      m1_r = expv(bk, byp, r);
      m1_g = expv(bk, byp, g);
      m1_b = expv(bk, byp, b);
      m1_t = tag;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      total++;
      bad++;
      $display("FAIL R2: watchdog got %0d cycles exp <= %0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k <= 64; k++) begin
      ftab[0][k] = ref_curve(5, 9, 16 * k);
      ftab[1][k] = ref_curve(1, 2, 16 * k);
      ftab[2][k] = ref_curve(5, 11, 16 * k);
    end
    repeat (3) @(negedge clk_i);
    // R1: outputs during reset
    check_out();
    rst_ni = 1'b1;

    // R3 R4: full sweep on each bank, lanes given distinct codes
    for (int bk = 0; bk < 3; bk++)
      for (int x = 0; x < 1024; x++)
        step(1'b1, x, 1023 - x, (x * 37) % 1024, bk, 1'b0, "R3 R4");

    // R10: end points
    for (int bk = 0; bk < 4; bk++) begin
      step(1'b1, 0, 1023, 0, bk, 1'b0, "R10");
      step(1'b1, 1023, 0, 1023, bk, 1'b0, "R10");
    end

    // R5: code 3 behaves as code 2
    for (int i = 0; i < 200; i++)
      step(1'b1, $urandom % 1024, $urandom % 1024, $urandom % 1024, 3, 1'b0, "R5");

    // R6: bypass
    for (int i = 0; i < 100; i++)
      step(1'b1, $urandom % 1024, $urandom % 1024, $urandom % 1024, $urandom % 4, 1'b1, "R6");

    // R7: equal and unequal lanes
    for (int i = 0; i < 100; i++) begin
      int x = $urandom % 1024;
      step(1'b1, x, x, (i % 2 == 0) ? x : (x ^ 10'h155), i % 3, 1'b0, "R7");
    end

    // R8: bank and bypass change on every pixel
    for (int i = 0; i < 400; i++)
      step(1'b1, $urandom % 1024, $urandom % 1024, $urandom % 1024,
           $urandom % 4, 1'($urandom % 2), "R8");

    // R2 R9: gaps in the strobe, inputs moving while idle
    for (int i = 0; i < 400; i++)
      step(1'($urandom % 2), $urandom % 1024, $urandom % 1024, $urandom % 1024,
           $urandom % 4, 1'($urandom % 2), "R2 R9");

    repeat (4) step(1'b0, 1023, 511, 7, 1, 1'b0, "R9");
    summary();
    $finish;
  end
endmodule